// File: doc/BRIEF.md
# Three-Phase Output Enable Guard

This block sits between a three-phase PWM generator and six motor-drive pins. Each phase has a positive and a negative pin. The block maps the raw active levels onto pin levels through a polarity choice, and it drives each pin's tri-state enable. The pins are released to high impedance unless the drive mode is on and the output-enable bit is set. A per-pin disable mask can also float any single pin.

The output-enable bit is cleared by software, by a falling edge on the active-low shutdown input, or by the overlap protection. The shutdown input is first passed through two flops. The overlap protection fires when both pins of any phase are commanded active in the same cycle. When it fires, a sticky detect flag is raised, and software can only clear that flag. Software cannot set output-enable while the synchronized shutdown level is low.

Top module: `phase_out_guard`

## Requirements
- R1: After reset, every control field reads 0 and all six pin enables are 0.
- R2: Pin enables are indexed with pin 2i for the positive side of phase i and pin 2i+1 for the negative side. Each pin enable is 1 exactly when the drive mode is 1, output-enable is 1 and that pin's disable bit is 0.
- R3: When the polarity bit is 0, each pin level equals its raw active level. When the polarity bit is 1, the pin level is the inverse. The pin index order is the one given in R2.
- R4: A write with wr_en updates the control word, which reads back on ctrl_q after the clock edge. Its layout is bit0 output-enable, bit1 overlap protection, bit2 detect flag, bit3 polarity (1 = active low) and bit4 drive mode.
- R5: A high-to-low transition on sd_n clears output-enable on the third rising edge after the change, counting the two synchronizer stages.
- R6: A write of 1 to output-enable has no effect while the synchronized sd_n is low.
- R7: If protection and drive mode are both 1 and the raw positive and negative levels of any phase are both 1, then the next edge sets the detect flag and clears output-enable.
- R8: With protection at 0, an overlap neither sets the flag nor clears output-enable.
- R9: A write of 0 to the detect flag clears it, and a write of 1 leaves it unchanged. A hardware set in the same cycle wins over a clear.
- R10: A pin whose disable bit is 1 has its enable at 0 while output-enable is 1, and the other pins keep their enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 5 | Control word write value |
| pwm_p | input | 3 | Raw active levels, positive side per phase |
| pwm_n | input | 3 | Raw active levels, negative side per phase |
| sd_n | input | 1 | Asynchronous active-low shutdown |
| pin_dis | input | 6 | Per-pin disable mask |
| pin_out | output | 6 | Pin levels |
| pin_oe | output | 6 | Pin tri-state enables (1 = driven) |
| ctrl_q | output | 5 | Control word readback |

## Verification
The assertions assume that sd_n only reaches the guard through its own synchronizer. They also assume that the raw PWM levels and the write strobe are stable around each rising edge. The bench therefore changes every input, sd_n included, only on the falling clock edge. The bench writes whole control words so that fields it does not test keep known values. It also times the shutdown checks from the edge on which the synchronizer first samples the low level.

// File: rtl/phase_out_guard.sv
module phase_out_guard #(
  parameter int NPH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [4:0]       wr_data,
  input  logic [NPH-1:0]   pwm_p,
  input  logic [NPH-1:0]   pwm_n,
  input  logic             sd_n,
  input  logic [2*NPH-1:0] pin_dis,
  output logic [2*NPH-1:0] pin_out,
  output logic [2*NPH-1:0] pin_oe,
  output logic [4:0]       ctrl_q
);
  localparam int NPIN = 2 * NPH;

  logic oe_q, prot_q, flag_q, pol_q, mode_q;
  logic sd_s1, sd_s2, sd_s3;
  logic sd_fall, overlap, trip;

  assign sd_fall = sd_s3 & ~sd_s2;
  assign overlap = |(pwm_p & pwm_n);
  assign trip    = overlap & prot_q & mode_q;
  assign ctrl_q  = {mode_q, pol_q, flag_q, prot_q, oe_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_s1 <= 1'b1;
      sd_s2 <= 1'b1;
      sd_s3 <= 1'b1;
    end else begin
      sd_s1 <= sd_n;
      sd_s2 <= sd_s1;
      sd_s3 <= sd_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      prot_q <= 1'b0;
      flag_q <= 1'b0;
      pol_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (wr_en) begin
        prot_q <= wr_data[1];
        pol_q  <= wr_data[3];
        mode_q <= wr_data[4];
      end
      if (sd_fall || trip)
        oe_q <= 1'b0;
      else if (wr_en)
        oe_q <= wr_data[0] & sd_s2;
      if (trip)
        flag_q <= 1'b1;
      else if (wr_en && !wr_data[2])
        flag_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    assign pin_out[2*i]   = pwm_p[i] ^ pol_q;
    assign pin_out[2*i+1] = pwm_n[i] ^ pol_q;
  end

  assign pin_oe = {NPIN{mode_q & oe_q}} & ~pin_dis;
endmodule

module phase_out_guard_chk #(
  parameter int NPH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [4:0]       wr_data,
  input logic [NPH-1:0]   pwm_p,
  input logic [NPH-1:0]   pwm_n,
  input logic             sd_ok,
  input logic [2*NPH-1:0] pin_dis,
  input logic [2*NPH-1:0] pin_oe,
  input logic [4:0]       ctrl_q
);
  a_r2_float_unless_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != '0) |-> (ctrl_q[0] && ctrl_q[4]));

  a_r10_masked_pins_float: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_dis) == '0);

  a_r6_set_needs_shutdown_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[0]) |-> $past(wr_en && wr_data[0] && sd_ok));

  a_r7_overlap_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && ctrl_q[4] && (pwm_p & pwm_n) != '0) |=> (!ctrl_q[0] && ctrl_q[2]));

  a_r9_flag_set_by_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[2]) |-> $past(ctrl_q[1] && ctrl_q[4] && (pwm_p & pwm_n) != '0));

  a_r9_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[2]) |-> $past(wr_en && !wr_data[2]));
endmodule

bind phase_out_guard phase_out_guard_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .pwm_p(pwm_p), .pwm_n(pwm_n), .sd_ok(sd_s2), .pin_dis(pin_dis),
  .pin_oe(pin_oe), .ctrl_q(ctrl_q)
);

// File: tb/phase_out_guard_test.sv
module phase_out_guard_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [2:0] pwm_p = '0;
  logic [2:0] pwm_n = '0;
  logic       sd_n = 1'b1;
  logic [5:0] pin_dis = '0;
  logic [5:0] pin_out, pin_oe;
  logic [4:0] ctrl_q;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  phase_out_guard uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .sd_n(sd_n), .pin_dis(pin_dis),
    .pin_out(pin_out), .pin_oe(pin_oe), .ctrl_q(ctrl_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", 32'(ctrl_q), 32'h0);
    chk("R1 oe", 32'(pin_oe), 32'h0);
  endtask

  task automatic t_enable_and_polarity;
    wr(5'b10011);
    chk("R4 readback", 32'(ctrl_q), 32'h13);
    chk("R2 all driven", 32'(pin_oe), 32'h3f);
    pwm_p = 3'b101; pwm_n = 3'b010;
    #1;
    chk("R3 active high", 32'(pin_out), 32'b011001);
    wr(5'b11011);
    chk("R3 active low", 32'(pin_out), 32'b100110);
    wr(5'b01011);
    chk("R2 mode off floats", 32'(pin_oe), 32'h0);
    wr(5'b10010);
    chk("R4 software clear", 32'(ctrl_q[0]), 32'h0);
    pwm_p = '0; pwm_n = '0;
  endtask

  task automatic t_mask;
    wr(5'b10001);
    pin_dis = 6'b100100;
    #1;
    chk("R10 masked", 32'(pin_oe), 32'b011011);
    pin_dis = '0;
  endtask

  task automatic t_shutdown;
    wr(5'b10001);
    @(negedge clk);
    sd_n = 1'b0;
    idle(2);
    chk("R5 still set after two edges", 32'(ctrl_q[0]), 32'h1);
    idle(1);
    chk("R5 cleared on third edge", 32'(ctrl_q[0]), 32'h0);
    chk("R5 pins float", 32'(pin_oe), 32'h0);
    wr(5'b10001);
    chk("R6 set ignored", 32'(ctrl_q[0]), 32'h0);
    sd_n = 1'b1;
    idle(3);
    wr(5'b10001);
    chk("R6 set after release", 32'(ctrl_q[0]), 32'h1);
  endtask

  task automatic t_overlap;
    wr(5'b10001);
    pwm_p = 3'b010; pwm_n = 3'b010;
    idle(2);
    chk("R8 no trip unprotected", 32'(ctrl_q), 32'h11);
    pwm_p = '0; pwm_n = '0;
    wr(5'b10011);
    pwm_p = 3'b100; pwm_n = 3'b100;
    idle(1);
    chk("R7 trip", 32'(ctrl_q), 32'h16);
    chk("R7 pins float", 32'(pin_oe), 32'h0);
    pwm_p = '0; pwm_n = '0;
    wr(5'b10110);
    chk("R9 write one keeps flag", 32'(ctrl_q[2]), 32'h1);
    pwm_p = 3'b001; pwm_n = 3'b001;
    wr(5'b10010);
    chk("R9 hw set beats clear", 32'(ctrl_q[2]), 32'h1);
    pwm_p = '0; pwm_n = '0;
    wr(5'b10010);
    chk("R9 write zero clears", 32'(ctrl_q[2]), 32'h0);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_enable_and_polarity();
    t_mask();
    t_shutdown();
    t_overlap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule